// File: doc/BRIEF.md
# Multi-Core Hardware Semaphore Bank

This block is a bank of hardware locks that several processor cores share for mutual exclusion. Each core has its own single-cycle register port into the bank. Every lock is one 32-bit register. To claim a lock, a core writes a request word that carries the lock flag and its own identifier. It then reads the register back. The claim succeeded only if the read returns exactly the word that was written. To release a lock, the core writes its identifier with the lock flag clear.

Each lock stores only two things: whether it is held, and which core holds it. A claim on a lock that is already held changes nothing. A release is accepted only from the current owner. When several cores write the same lock in the same cycle, a fixed priority settles the race, so a losing core sees a mismatch on its read-back.

Top module: `hsem_bank`

## Requirements
- R1: After reset every lock is free, and a read of any lock returns 0.
- R2: Lock k sits at byte offset 4*k. Bits [ADDR_W-1:2] of the port address select the lock, and bits [1:0] are ignored. Read data is registered: the lock named by the address in cycle N appears on that port's read data after the clock edge that ends cycle N. It shows the state from before any write taken at that same edge.
- R3: Core c claims a free lock by writing 0x8000_0000 | (1 << (8+c)): bit 31 is the lock flag and bit 8+c is its identifier. The lock then becomes held with owner c.
- R4: A claim word written to a lock that is already held, by any core, leaves the lock's owner and state unchanged.
- R5: Core c releases a lock by writing 1 << (8+c). The write frees the lock only if c is the current owner. From any other core it has no effect.
- R6: A write whose data is neither the claim word nor the release word of the writing port is ignored.
- R7: A free lock reads as 0. A held lock reads as 0x8000_0000 | (1 << (8+owner)), with every other bit zero.
- R8: When several cores write the same lock in one cycle, only the valid write from the lowest-numbered core is applied. The writes from the other cores are dropped, including a release from the owner.
- R9: Writes to byte offsets at or above 4*NUM_LOCKS change no lock. Reads from those offsets return 0.
- R10: The locks are independent. A write to one lock never changes another lock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | NUM_CORES | Write strobe, one bit per core |
| bus_addr | input | NUM_CORES*ADDR_W | Byte address for each core; core c uses slice [c*ADDR_W +: ADDR_W] |
| bus_wdata | input | NUM_CORES*32 | Write data for each core; core c uses slice [c*32 +: 32] |
| bus_rdata | output | NUM_CORES*32 | Registered read data for each core; core c uses slice [c*32 +: 32] |

## Verification
The assertions assume that NUM_CORES is small enough for every identifier bit to fit between bit 8 and bit 30. They also assume that each port's address and data are stable and fully driven on every clock edge after reset. The bench drives all inputs on the falling edge from a single task and never leaves an input undefined. It exercises every lock, all fifteen combinations of cores racing for one lock, every out-of-range word offset, and malformed data words. Under that stimulus, every claim and release stays inside the encodings that R3 and R5 define, except where R6 deliberately breaks them.

// File: rtl/hsem_pkg.sv
package hsem_pkg;
  localparam int DATA_W   = 32;
  localparam int FLAG_BIT = 31;
  localparam int ID_LSB   = 8;
  localparam logic [DATA_W-1:0] FLAG_MASK = DATA_W'(1) << FLAG_BIT;

  // Identifier word for a core: one bit at ID_LSB + core index.
  function automatic logic [DATA_W-1:0] core_id_word(input int core);
    return DATA_W'(1) << (ID_LSB + core);
  endfunction
endpackage

// File: rtl/hsem_port_decode.sv
module hsem_port_decode
  import hsem_pkg::*;
#(
  parameter int NUM_LOCKS = 32,
  parameter int ADDR_W    = 8,
  parameter int CORE      = 0,
  localparam int LIDX_W   = (NUM_LOCKS > 1) ? $clog2(NUM_LOCKS) : 1
) (
  input  logic              wr,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic              addr_ok,
  output logic [LIDX_W-1:0] idx,
  output logic              hit,
  output logic              claim
);
  localparam int WORD_W = ADDR_W - 2;
  localparam logic [DATA_W-1:0] REL_WORD   = core_id_word(CORE);
  localparam logic [DATA_W-1:0] CLAIM_WORD = FLAG_MASK | REL_WORD;

  logic [WORD_W-1:0] word;
  logic              is_claim;
  logic              is_release;

  always_comb begin
    word       = addr[ADDR_W-1:2];
    addr_ok    = ({{(32-WORD_W){1'b0}}, word} < 32'(NUM_LOCKS));
    idx        = word[LIDX_W-1:0];
    is_claim   = (wdata == CLAIM_WORD);
    is_release = (wdata == REL_WORD);
    hit        = wr && addr_ok && (is_claim || is_release);
    claim      = is_claim;
  end
endmodule

// File: rtl/hsem_lock_slot.sv
module hsem_lock_slot #(
  parameter int NUM_CORES = 4,
  localparam int CORE_W   = (NUM_CORES > 1) ? $clog2(NUM_CORES) : 1
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [NUM_CORES-1:0] req,
  input  logic [NUM_CORES-1:0] claim,
  output logic                 held,
  output logic [CORE_W-1:0]    owner
);
  logic              found;
  logic [CORE_W-1:0] sel;
  logic              sel_claim;

  // Fixed priority: the lowest-numbered requesting core is selected.
  always_comb begin
    found     = 1'b0;
    sel       = '0;
    sel_claim = 1'b0;
    for (int c = NUM_CORES - 1; c >= 0; c--) begin
      if (req[c]) begin
        found     = 1'b1;
        sel       = CORE_W'(c);
        sel_claim = claim[c];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      held  <= 1'b0;
      owner <= '0;
    end else if (found) begin
      if (sel_claim && !held) begin
        held  <= 1'b1;
        owner <= sel;
      end else if (!sel_claim && held && (owner == sel)) begin
        held  <= 1'b0;
        owner <= '0;
      end
    end
  end
endmodule

// File: rtl/hsem_read_port.sv
module hsem_read_port
  import hsem_pkg::*;
#(
  parameter int NUM_LOCKS = 32,
  parameter int NUM_CORES = 4,
  localparam int LIDX_W   = (NUM_LOCKS > 1) ? $clog2(NUM_LOCKS) : 1,
  localparam int CORE_W   = (NUM_CORES > 1) ? $clog2(NUM_CORES) : 1
) (
  input  logic                              clk,
  input  logic                              rst,
  input  logic                              addr_ok,
  input  logic [LIDX_W-1:0]                 idx,
  input  logic [NUM_LOCKS-1:0]              lock_held,
  input  logic [NUM_LOCKS-1:0][CORE_W-1:0]  lock_owner,
  output logic [DATA_W-1:0]                 rdata
);
  logic [DATA_W-1:0] nxt;

  always_comb begin
    nxt = '0;
    if (addr_ok && lock_held[idx]) begin
      nxt = FLAG_MASK | (DATA_W'(1) << (ID_LSB + int'(lock_owner[idx])));
    end
  end

  always_ff @(posedge clk) begin
    if (rst) rdata <= '0;
    else     rdata <= nxt;
  end
endmodule

// File: rtl/hsem_bank.sv
module hsem_bank
  import hsem_pkg::*;
#(
  parameter int NUM_CORES = 4,   // identifiers use bits 8 .. 8+NUM_CORES-1, keep below 31
  parameter int NUM_LOCKS = 32,
  parameter int ADDR_W    = 8
) (
  input  logic                           clk,
  input  logic                           rst,
  input  logic [NUM_CORES-1:0]           bus_wr,
  input  logic [NUM_CORES*ADDR_W-1:0]    bus_addr,
  input  logic [NUM_CORES*DATA_W-1:0]    bus_wdata,
  output logic [NUM_CORES*DATA_W-1:0]    bus_rdata
);
  localparam int LIDX_W = (NUM_LOCKS > 1) ? $clog2(NUM_LOCKS) : 1;
  localparam int CORE_W = (NUM_CORES > 1) ? $clog2(NUM_CORES) : 1;

  logic [NUM_CORES-1:0]              port_ok;
  logic [NUM_CORES-1:0]              port_hit;
  logic [NUM_CORES-1:0]              port_claim;
  logic [NUM_CORES-1:0][LIDX_W-1:0]  port_idx;
  logic [NUM_LOCKS-1:0]              lock_held;
  logic [NUM_LOCKS-1:0][CORE_W-1:0]  lock_owner;

  for (genvar c = 0; c < NUM_CORES; c++) begin : g_port
    hsem_port_decode #(
      .NUM_LOCKS (NUM_LOCKS),
      .ADDR_W    (ADDR_W),
      .CORE      (c)
    ) u_dec (
      .wr      (bus_wr[c]),
      .addr    (bus_addr[c*ADDR_W +: ADDR_W]),
      .wdata   (bus_wdata[c*DATA_W +: DATA_W]),
      .addr_ok (port_ok[c]),
      .idx     (port_idx[c]),
      .hit     (port_hit[c]),
      .claim   (port_claim[c])
    );

    hsem_read_port #(
      .NUM_LOCKS (NUM_LOCKS),
      .NUM_CORES (NUM_CORES)
    ) u_rd (
      .clk        (clk),
      .rst        (rst),
      .addr_ok    (port_ok[c]),
      .idx        (port_idx[c]),
      .lock_held  (lock_held),
      .lock_owner (lock_owner),
      .rdata      (bus_rdata[c*DATA_W +: DATA_W])
    );
  end

  for (genvar l = 0; l < NUM_LOCKS; l++) begin : g_lock
    logic [NUM_CORES-1:0] req;

    always_comb begin
      for (int c = 0; c < NUM_CORES; c++) begin
        req[c] = port_hit[c] && (port_idx[c] == LIDX_W'(l));
      end
    end

    hsem_lock_slot #(
      .NUM_CORES (NUM_CORES)
    ) u_slot (
      .clk   (clk),
      .rst   (rst),
      .req   (req),
      .claim (port_claim),
      .held  (lock_held[l]),
      .owner (lock_owner[l])
    );
  end
endmodule

// File: rtl/hsem_bank_checker.sv
module hsem_bank_checker
  import hsem_pkg::*;
#(
  parameter int NUM_CORES = 4,
  parameter int NUM_LOCKS = 32,
  parameter int ADDR_W    = 8,
  localparam int CORE_W   = (NUM_CORES > 1) ? $clog2(NUM_CORES) : 1
) (
  input logic                           clk,
  input logic                           rst,
  input logic [NUM_CORES-1:0]           bus_wr,
  input logic [NUM_CORES*ADDR_W-1:0]    bus_addr,
  input logic [NUM_CORES*DATA_W-1:0]    bus_wdata,
  input logic [NUM_CORES*DATA_W-1:0]    bus_rdata,
  input logic [NUM_LOCKS-1:0]           lock_held,
  input logic [NUM_LOCKS-1:0][CORE_W-1:0] lock_owner
);
  localparam int WORD_W = ADDR_W - 2;
  localparam logic [DATA_W-1:0] ID_FIELD = ((DATA_W'(1) << NUM_CORES) - 1) << ID_LSB;

  logic [NUM_LOCKS-1:0] owner_release;
  logic [NUM_CORES-1:0] addr_oor;

  always_comb begin
    owner_release = '0;
    addr_oor      = '0;
    for (int c = 0; c < NUM_CORES; c++) begin
      logic [ADDR_W-1:0] a;
      logic [WORD_W-1:0] w;
      a = bus_addr[c*ADDR_W +: ADDR_W];
      w = a[ADDR_W-1:2];
      addr_oor[c] = !({{(32-WORD_W){1'b0}}, w} < 32'(NUM_LOCKS));
      for (int l = 0; l < NUM_LOCKS; l++) begin
        if (bus_wr[c] && !addr_oor[c] && (32'(w) == 32'(l)) &&
            (bus_wdata[c*DATA_W +: DATA_W] == core_id_word(c)) &&
            lock_held[l] && (lock_owner[l] == CORE_W'(c)))
          owner_release[l] = 1'b1;
      end
    end
  end

  // R1: the edge after reset leaves every lock free
  a_r1_reset_frees: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (lock_held == '0));

  for (genvar c = 0; c < NUM_CORES; c++) begin : g_core
    // R1: read data is zero straight after reset
    a_r1_reset_rdata: assert property (@(posedge clk) disable iff (rst)
      $past(rst) |-> (bus_rdata[c*DATA_W +: DATA_W] == '0));

    // R7: read data is zero, or the flag plus one identifier bit only
    a_r7_read_form: assert property (@(posedge clk) disable iff (rst)
      (bus_rdata[c*DATA_W +: DATA_W] == '0) ||
      (bus_rdata[c*DATA_W + FLAG_BIT] &&
       ($countones(bus_rdata[c*DATA_W +: DATA_W]) == 2) &&
       ((bus_rdata[c*DATA_W +: DATA_W] & ~(FLAG_MASK | ID_FIELD)) == '0)));

    // R9: an out-of-range address reads zero
    a_r9_oor_reads_zero: assert property (@(posedge clk) disable iff (rst)
      (!$past(rst) && $past(addr_oor[c])) |-> (bus_rdata[c*DATA_W +: DATA_W] == '0));
  end

  for (genvar l = 0; l < NUM_LOCKS; l++) begin : g_lk
    // R5: a lock is freed only by a release word from its owner
    a_r5_owner_release: assert property (@(posedge clk) disable iff (rst)
      (!$past(rst) && $past(lock_held[l]) && !lock_held[l]) |-> $past(owner_release[l]));

    // R4: while a lock stays held its owner never changes
    a_r4_owner_stable: assert property (@(posedge clk) disable iff (rst)
      (!$past(rst) && $past(lock_held[l]) && lock_held[l]) |-> $stable(lock_owner[l]));
  end
endmodule

bind hsem_bank hsem_bank_checker #(
  .NUM_CORES (NUM_CORES),
  .NUM_LOCKS (NUM_LOCKS),
  .ADDR_W    (ADDR_W)
) u_chk (
  .clk        (clk),
  .rst        (rst),
  .bus_wr     (bus_wr),
  .bus_addr   (bus_addr),
  .bus_wdata  (bus_wdata),
  .bus_rdata  (bus_rdata),
  .lock_held  (lock_held),
  .lock_owner (lock_owner)
);

// File: tb/hsem_bank_tb.sv
`timescale 1ns/1ps
module hsem_bank_tb;
  localparam int NC = 4;
  localparam int NL = 32;
  localparam int AW = 8;

  logic            clk = 1'b0;
  logic            rst = 1'b1;
  logic [NC-1:0]   bus_wr = '0;
  logic [NC*AW-1:0] bus_addr = '0;
  logic [NC*32-1:0] bus_wdata = '0;
  logic [NC*32-1:0] bus_rdata;

  int checks = 0;
  int failures = 0;

  // pending writes for the next commit
  logic [NC-1:0] tw;
  logic [AW-1:0] ta [NC];
  logic [31:0]   td [NC];

  // reference model
  bit mh [NL];
  int mo [NL];

  always #2.5 clk = ~clk;

  hsem_bank #(.NUM_CORES(NC), .NUM_LOCKS(NL), .ADDR_W(AW)) u_dut (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata));

  function automatic logic [31:0] idw(input int c);
    return 32'h1 << (8 + c);
  endfunction

  function automatic logic [31:0] expect_word(input int l);
    return mh[l] ? (32'h8000_0000 | idw(mo[l])) : 32'h0;
  endfunction

  task automatic clear_pending();
    tw = '0;
    for (int c = 0; c < NC; c++) begin ta[c] = '0; td[c] = '0; end
  endtask

  task automatic add_wr(input int c, input int byte_addr, input logic [31:0] d);
    tw[c] = 1'b1; ta[c] = AW'(byte_addr); td[c] = d;
  endtask

  // Model from R3..R10: per lock, lowest valid writer applies.
  task automatic model_update();
    for (int l = 0; l < NL; l++) begin
      int sel = -1;
      for (int c = NC - 1; c >= 0; c--) begin
        if (tw[c] && (int'(ta[c]) < 4*NL) && (int'(ta[c]) / 4 == l) &&
            (td[c] == (32'h8000_0000 | idw(c)) || td[c] == idw(c)))
          sel = c;
      end
      if (sel >= 0) begin
        if (td[sel][31] && !mh[l]) begin mh[l] = 1'b1; mo[l] = sel; end
        else if (!td[sel][31] && mh[l] && mo[l] == sel) mh[l] = 1'b0;
      end
    end
  endtask

  task automatic commit();
    @(negedge clk);
    for (int c = 0; c < NC; c++) begin
      bus_wr[c] = tw[c];
      bus_addr[c*AW +: AW] = ta[c];
      bus_wdata[c*32 +: 32] = td[c];
    end
    model_update();
    @(negedge clk);
    bus_wr = '0;
    clear_pending();
  endtask

  task automatic check(input string tag, input int c, input logic [31:0] got,
                       input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s core=%0d actual=%h expected=%h", tag, c, got, exp);
    end
  endtask

  // Every core reads lock l; each uses different low address bits (R2).
  task automatic check_all(input int l, input string tag);
    @(negedge clk);
    bus_wr = '0;
    for (int c = 0; c < NC; c++) bus_addr[c*AW +: AW] = AW'(l*4 + c);
    @(negedge clk);
    for (int c = 0; c < NC; c++) check(tag, c, bus_rdata[c*32 +: 32], expect_word(l));
  endtask

  initial begin
    #(150000 * 5);
    failures++;
    $display("FAIL watchdog actual=timeout expected=completion");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    for (int l = 0; l < NL; l++) begin mh[l] = 1'b0; mo[l] = 0; end
    clear_pending();
    repeat (4) @(negedge clk);
    rst = 1'b0;

    // R1: everything free after reset
    for (int l = 0; l < NL; l++) check_all(l, "R1");

    // R3 R4 R5 R6 per lock
    for (int l = 0; l < NL; l++) begin
      int c = l % NC;
      int d = (c + 1) % NC;
      clear_pending(); add_wr(c, l*4, 32'h8000_0000 | idw(c)); commit();
      check_all(l, "R3");
      clear_pending(); add_wr(d, l*4, 32'h8000_0000 | idw(d)); commit();
      check_all(l, "R4");
      clear_pending(); add_wr(d, l*4, idw(d)); commit();
      check_all(l, "R5");
      clear_pending(); add_wr(c, l*4, 32'h8000_0000); commit();
      check_all(l, "R6");
      clear_pending(); add_wr(c, l*4, idw(d)); commit();
      check_all(l, "R6");
      clear_pending(); add_wr(c, l*4, idw(c) | 32'h1); commit();
      check_all(l, "R6");
      clear_pending(); add_wr(c, l*4, idw(c)); commit();
      check_all(l, "R5");
    end

    // R8: every combination of racing claimers on lock 7
    for (int m = 1; m < (1 << NC); m++) begin
      clear_pending();
      for (int c = 0; c < NC; c++) if (m[c]) add_wr(c, 7*4, 32'h8000_0000 | idw(c));
      commit();
      check_all(7, "R8");
      clear_pending(); add_wr(mo[7], 7*4, idw(mo[7])); commit();
      check_all(7, "R8");
    end
    // R8: owner release dropped when a lower core writes in the same cycle
    clear_pending(); add_wr(3, 9*4, 32'h8000_0000 | idw(3)); commit();
    clear_pending(); add_wr(1, 9*4, 32'h8000_0000 | idw(1)); add_wr(3, 9*4, idw(3)); commit();
    check_all(9, "R8");
    clear_pending(); add_wr(3, 9*4, idw(3)); commit();
    check_all(9, "R8");

    // R9: out-of-range writes and reads
    for (int a = 4*NL; a < (1 << AW); a += 4) begin
      clear_pending(); add_wr(0, a, 32'h8000_0000 | idw(0)); commit();
      @(negedge clk);
      bus_addr[0 +: AW] = AW'(a);
      @(negedge clk);
      check("R9", 0, bus_rdata[0 +: 32], 32'h0);
    end
    for (int l = 0; l < NL; l++) check_all(l, "R9");

    // R10: many locks held at once by different cores
    for (int l = 0; l < NL; l += NC) begin
      clear_pending();
      for (int c = 0; c < NC; c++)
        if (((l + c) % 3) != 0) add_wr(c, (l + c)*4, 32'h8000_0000 | idw(c));
      commit();
    end
    for (int l = 0; l < NL; l++) check_all(l, "R10");
    for (int l = 0; l < NL; l++) if (mh[l]) begin
      clear_pending(); add_wr(mo[l], l*4, idw(mo[l])); commit();
    end
    for (int l = 0; l < NL; l++) check_all(l, "R10");

    // R2: read in the same cycle as a claim shows the old state
    @(negedge clk);
    bus_wr[0] = 1'b1;
    bus_addr[0 +: AW] = AW'(20*4);
    bus_wdata[0 +: 32] = 32'h8000_0000 | idw(0);
    bus_addr[AW +: AW] = AW'(20*4 + 3);
    @(negedge clk);
    bus_wr = '0;
    check("R2", 1, bus_rdata[32 +: 32], 32'h0);
    @(negedge clk);
    check("R2", 1, bus_rdata[32 +: 32], 32'h8000_0000 | idw(0));

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule